// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Radio-State Pin Muxing

This peripheral owns 32 general-purpose pins, grouped as a receive bank (pins 15:0) and a transmit bank (pins 31:16). Software programs each pin's direction and picks, through a 2-bit field per pin, what drives it when it is an output. The choices are a software-written level, a value looked up from the current radio state, or one of two debug buses from the fabric. The radio state comes from two live flags, `tx_active` and `rx_active`. Each bank holds four 16-bit state values: idle, transmit only, receive only and full duplex. The value for the current state reaches the pins in the same cycle the flags change, with no register in between.

Software reaches the block over a plain register bus. A write takes one cycle. A read is strobed with `rd_en`, and its data appears on `rdata` one cycle later. The bus has no back-pressure, so every access completes. Pads are modelled as separate output, output-enable and input vectors. Pin inputs pass through a two-flop synchronizer before software can read them.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset, every register reads as zero, `pad_oe` is all zero and `pad_out` is all zero.
- R2: A 32-bit write to byte address 0x04 sets the direction word, where 1 means output. Bits 15:0 cover the receive bank and bits 31:16 the transmit bank. `pad_oe` equals this word.
- R3: A pin whose direction bit is 0 drives `pad_out` low whatever its select field holds.
- R4: Select code 0 drives an output pin from the software level word, which is written at byte address 0x00.
- R5: Select code 1 drives an output pin from its bank's state value for state index {rx_active, tx_active}: 0 is idle, 1 is transmit only, 2 is receive only and 3 is full duplex.
- R6: Select code 2 drives an output pin from `dbg0` at the same bit. Select code 3 drives it from `dbg1`.
- R7: The transmit-bank select word is at 0x08 and the receive-bank select word is at 0x0C. The field for bank pin i sits at bits 2i+1:2i, and each word affects only its own bank.
- R8: The state values for state s sit at byte 0x10+4s. The transmit-bank half is at +0 and the receive-bank half at +2. A 16-bit write (`wr_half`=1, data in `wdata[15:0]`) changes only the addressed half. A 32-bit write sets the transmit half from bits 15:0 and the receive half from bits 31:16.
- R9: A read returns data on `rdata` on the cycle after `rd_en`. Address 0x00 returns the pin levels after the two-flop synchronizer. Addresses 0x04, 0x08 and 0x0C return their words. Address 0x10+4s returns {receive half, transmit half}.
- R10: A change of `tx_active`/`rx_active` changes pins on code 1 in the same cycle. With flags, debug buses and registers all steady, `pad_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_half | input | 1 | 1 selects a 16-bit write to a state half |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| tx_active | input | 1 | Radio transmitting |
| rx_active | input | 1 | Radio receiving |
| dbg0 | input | 32 | Debug bus 0 |
| dbg1 | input | 32 | Debug bus 1 |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Pin output levels |
| pad_oe | output | 32 | Pin output enables |

## Verification
The bench walks all four radio states with distinct per-bank state values. A design that swapped the state index bits, or swapped the banks, would show the transmit-only pattern in the receive-only state, or the receive-bank value on the transmit pins. It writes a single half of one state value and reads the whole word back. A design that ignored the half strobe would clobber the neighbouring half. It mixes all four select codes across adjacent pins of each bank, which catches off-by-one field slicing and a transposed select-word address. It also confirms that pins set as inputs stay low even when their select field holds a non-zero code.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  // per-pin source codes
  localparam logic [1:0] SRC_SW   = 2'd0;
  localparam logic [1:0] SRC_ATR  = 2'd1;
  localparam logic [1:0] SRC_DBG0 = 2'd2;
  localparam logic [1:0] SRC_DBG1 = 2'd3;
  // word index within the pin register region (addr[3:2])
  localparam logic [1:0] WORD_IO    = 2'd0;
  localparam logic [1:0] WORD_DIR   = 2'd1;
  localparam logic [1:0] WORD_TXSEL = 2'd2;
  localparam logic [1:0] WORD_RXSEL = 2'd3;
  localparam int NUM_STATES = 4;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int BANK_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic                                       wr_half,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic [2*BANK_W-1:0]                        wdata,
  output logic [2*BANK_W-1:0]                        io_q,
  output logic [2*BANK_W-1:0]                        dir_q,
  output logic [2*BANK_W-1:0]                        txsel_q,
  output logic [2*BANK_W-1:0]                        rxsel_q,
  output logic [gpio_atr_pkg::NUM_STATES-1:0][BANK_W-1:0] atr_tx_q,
  output logic [gpio_atr_pkg::NUM_STATES-1:0][BANK_W-1:0] atr_rx_q
);
  import gpio_atr_pkg::*;

  logic       in_atr;
  logic [1:0] word;
  assign in_atr = addr[4];
  assign word   = addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      io_q     <= '0;
      dir_q    <= '0;
      txsel_q  <= '0;
      rxsel_q  <= '0;
      atr_tx_q <= '0;
      atr_rx_q <= '0;
    end else if (wr_en) begin
      if (!in_atr) begin
        unique case (word)
          WORD_IO:    io_q    <= wdata;
          WORD_DIR:   dir_q   <= wdata;
          WORD_TXSEL: txsel_q <= wdata;
          default:    rxsel_q <= wdata;
        endcase
      end else if (wr_half) begin
        if (addr[1]) atr_rx_q[word] <= wdata[BANK_W-1:0];
        else         atr_tx_q[word] <= wdata[BANK_W-1:0];
      end else begin
        atr_tx_q[word] <= wdata[BANK_W-1:0];
        atr_rx_q[word] <= wdata[2*BANK_W-1:BANK_W];
      end
    end
  end

  // R2: a full write to the direction word lands there
  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_half && addr == 5'h04) |=> (dir_q == $past(wdata)));

  // R8: a transmit-half write leaves every receive half alone
  a_r8_half_keeps_other: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_half && addr[4] && !addr[1]) |=> $stable(atr_rx_q));
endmodule

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux #(
  parameter int BANK_W = 16
) (
  input  logic [BANK_W-1:0]   sw_val,
  input  logic [BANK_W-1:0]   dir,
  input  logic [2*BANK_W-1:0] sel,
  input  logic [BANK_W-1:0]   atr_val,
  input  logic [BANK_W-1:0]   dbg0,
  input  logic [BANK_W-1:0]   dbg1,
  output logic [BANK_W-1:0]   pin_out
);
  import gpio_atr_pkg::*;

  for (genvar i = 0; i < BANK_W; i++) begin : g_pin
    logic [1:0] code;
    logic       src;
    assign code = sel[2*i +: 2];
    always_comb begin
      unique case (code)
        SRC_SW:   src = sw_val[i];
        SRC_ATR:  src = atr_val[i];
        SRC_DBG0: src = dbg0[i];
        default:  src = dbg1[i];
      endcase
    end
    assign pin_out[i] = dir[i] & src;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl #(
  parameter int BANK_W = 16,
  parameter int ADDR_W = 5,
  localparam int PINS  = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_half,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic [PINS-1:0]   dbg0,
  input  logic [PINS-1:0]   dbg1,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  import gpio_atr_pkg::*;

  logic [PINS-1:0] io_q, dir_q, txsel_q, rxsel_q, pins_sync;
  logic [NUM_STATES-1:0][BANK_W-1:0] atr_tx_q, atr_rx_q;
  logic [1:0] state_idx;

  gpio_regfile #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_half(wr_half), .addr(addr),
    .wdata(wdata), .io_q(io_q), .dir_q(dir_q), .txsel_q(txsel_q),
    .rxsel_q(rxsel_q), .atr_tx_q(atr_tx_q), .atr_rx_q(atr_rx_q)
  );

  gpio_in_sync #(.W(PINS)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(pins_sync)
  );

  assign state_idx = {rx_active, tx_active};

  // bank 0 = receive side (low pins), bank 1 = transmit side (high pins)
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [2*BANK_W-1:0] sel_w;
    logic [BANK_W-1:0]   atr_w;
    if (b == 0) begin : g_rx
      assign sel_w = rxsel_q;
      assign atr_w = atr_rx_q[state_idx];
    end else begin : g_tx
      assign sel_w = txsel_q;
      assign atr_w = atr_tx_q[state_idx];
    end
    gpio_bank_mux #(.BANK_W(BANK_W)) mux_i (
      .sw_val (io_q[b*BANK_W +: BANK_W]),
      .dir    (dir_q[b*BANK_W +: BANK_W]),
      .sel    (sel_w),
      .atr_val(atr_w),
      .dbg0   (dbg0[b*BANK_W +: BANK_W]),
      .dbg1   (dbg1[b*BANK_W +: BANK_W]),
      .pin_out(pad_out[b*BANK_W +: BANK_W])
    );
  end

  assign pad_oe = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!addr[4]) begin
        unique case (addr[3:2])
          WORD_IO:    rdata <= pins_sync;
          WORD_DIR:   rdata <= dir_q;
          WORD_TXSEL: rdata <= txsel_q;
          default:    rdata <= rxsel_q;
        endcase
      end else begin
        rdata <= {atr_rx_q[addr[3:2]], atr_tx_q[addr[3:2]]};
      end
    end
  end

  // R3: input pins never show a driven level
  a_r3_inputs_quiet: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  // R9: direction read data appears one cycle after the strobe
  a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'h04) |=> (rdata == $past(dir_q)));

  // R10: with nothing moving, the pins hold
  a_r10_steady_pins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(tx_active) && $stable(rx_active)
     && $stable(dbg0) && $stable(dbg1)) |-> $stable(pad_out));
endmodule

// File: tb/gpio_atr_ctrl_tb_top.sv
module gpio_atr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_half, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        tx_active, rx_active;
  logic [31:0] dbg0, dbg1, pad_in, pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench copy of programmed state
  logic [31:0] io_m, dir_m, txsel_m, rxsel_m;
  logic [15:0] atr_tx_m [4];
  logic [15:0] atr_rx_m [4];

  always #4 clk = ~clk;

  gpio_atr_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_half(wr_half), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tx_active(tx_active),
    .rx_active(rx_active), .dbg0(dbg0), .dbg1(dbg1), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_out();
    logic [31:0] r;
    logic [1:0]  idx;
    idx = {rx_active, tx_active};
    for (int p = 0; p < 32; p++) begin
      logic [1:0] s;
      logic       a;
      s = (p < 16) ? rxsel_m[2*p +: 2] : txsel_m[2*(p-16) +: 2];
      a = (p < 16) ? atr_rx_m[idx][p] : atr_tx_m[idx][p-16];
      case (s)
        2'd0: r[p] = io_m[p];
        2'd1: r[p] = a;
        2'd2: r[p] = dbg0[p];
        default: r[p] = dbg1[p];
      endcase
      r[p] = r[p] & dir_m[p];
    end
    return r;
  endfunction

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_half = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (!a[4]) begin
      case (a[3:2])
        2'd0: io_m = d;
        2'd1: dir_m = d;
        2'd2: txsel_m = d;
        default: rxsel_m = d;
      endcase
    end else begin
      atr_tx_m[a[3:2]] = d[15:0];
      atr_rx_m[a[3:2]] = d[31:16];
    end
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_half = 1; addr = a; wdata = {16'hDEAD, d};
    @(negedge clk);
    wr_en = 0; wr_half = 0;
    if (a[1]) atr_rx_m[a[3:2]] = d;
    else      atr_tx_m[a[3:2]] = d;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic set_state(input logic tx, input logic rx);
    @(negedge clk);
    tx_active = tx; rx_active = rx;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    rd(5'h04, d); chk("R1 dir read", d, 32'h0);
    rd(5'h0C, d); chk("R1 rxsel read", d, 32'h0);
    rd(5'h18, d); chk("R1 state read", d, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] d;
    wr32(5'h04, 32'hFFFF_00F0);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_00F0);
    rd(5'h04, d); chk("R2/R9 dir read", d, 32'hFFFF_00F0);
  endtask

  task automatic t_software();
    wr32(5'h00, 32'hA5A5_5A5A);
    chk("R4 sw drive", pad_out, exp_out());
    chk("R3 inputs low", pad_out & ~pad_oe, 32'h0);
    wr32(5'h0C, 32'hFFFF_FFFF); // code 3 on receive bank, many inputs
    dbg1 = 32'hFFFF_FFFF; #1;
    chk("R3 input ignores select", pad_out & 32'h0000_FF0F, 32'h0);
    wr32(5'h0C, 32'h0);
  endtask

  task automatic t_states();
    wr32(5'h04, 32'hFFFF_FFFF);
    wr32(5'h08, 32'h5555_5555);
    wr32(5'h0C, 32'h5555_5555);
    wr32(5'h10, 32'h1111_EEEE);
    wr32(5'h14, 32'h2222_DDDD);
    wr32(5'h18, 32'h3333_CCCC);
    wr32(5'h1C, 32'h4444_BBBB);
    set_state(0, 0); chk("R5 idle", pad_out, 32'hEEEE_1111);
    set_state(1, 0); chk("R5/R10 tx only", pad_out, 32'hDDDD_2222);
    set_state(0, 1); chk("R5/R10 rx only", pad_out, 32'hCCCC_3333);
    set_state(1, 1); chk("R5/R10 full duplex", pad_out, 32'hBBBB_4444);
    repeat (3) @(negedge clk);
    chk("R10 steady", pad_out, 32'hBBBB_4444);
  endtask

  task automatic t_half();
    logic [31:0] d;
    wr16(5'h1A, 16'h1234);  // receive half of receive-only state
    rd(5'h18, d); chk("R8 rx half only", d, 32'h1234_CCCC);
    wr16(5'h14, 16'h0F0F);  // transmit half of transmit-only state
    rd(5'h14, d); chk("R8 tx half only", d, 32'h2222_0F0F);
    set_state(1, 0); chk("R8 half reaches pins", pad_out, 32'h0F0F_2222);
  endtask

  task automatic t_debug();
    dbg0 = 32'h1357_9BDF; dbg1 = 32'h2468_ACE0;
    wr32(5'h08, 32'hAAAA_AAAA);
    wr32(5'h0C, 32'hAAAA_AAAA);
    chk("R6 dbg0", pad_out, 32'h1357_9BDF);
    wr32(5'h08, 32'hFFFF_FFFF);
    wr32(5'h0C, 32'hFFFF_FFFF);
    chk("R6 dbg1", pad_out, 32'h2468_ACE0);
  endtask

  task automatic t_mixed();
    logic [31:0] d;
    wr32(5'h00, 32'hFFFF_FFFF);
    dbg0 = 32'h0000_0000; dbg1 = 32'hFFFF_FFFF;
    set_state(0, 0);
    wr32(5'h0C, 32'h1B1B_E4E4); // rx bank: codes cycle 0,1,2,3 then 3,2,1,0
    wr32(5'h08, 32'h0000_0000); // tx bank all software
    chk("R7 mixed fields", pad_out, exp_out());
    chk("R7 tx bank untouched", pad_out[31:16], 16'hFFFF);
    rd(5'h0C, d); chk("R7 rxsel read", d, 32'h1B1B_E4E4);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    @(negedge clk);
    pad_in = 32'hC0DE_F00D;
    repeat (3) @(negedge clk);
    rd(5'h00, d); chk("R9 pin readback", d, 32'hC0DE_F00D);
    pad_in = 32'h0;
    rd(5'h00, d); chk("R9 synchronizer delay", d, 32'hC0DE_F00D);
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_half = 0; rd_en = 0; addr = '0; wdata = '0;
    tx_active = 0; rx_active = 0; dbg0 = '0; dbg1 = '0; pad_in = '0;
    io_m = '0; dir_m = '0; txsel_m = '0; rxsel_m = '0;
    for (int i = 0; i < 4; i++) begin atr_tx_m[i] = '0; atr_rx_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_direction();
    t_software();
    t_states();
    t_half();
    t_debug();
    t_mixed();
    t_readback();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule